// File: doc/BRIEF.md
# Eight-Level Prioritised Interrupt Controller

This block collects up to eight interrupt request lines, latches them, removes any that software has masked, and selects one by fixed priority: level 0 wins over level 7. While a request is eligible, it holds an interrupt line to the processor high. The processor then answers with two acknowledge pulses. The first pulse moves the winning level from the pending register to the in-service register and leaves the data bus undriven. The second pulse drives an 8-bit vector onto the bus. The vector is made from a programmed base in its upper bits and the winning level in its low three bits.

A level that is in service blocks itself and every lower-priority level until it is released. Release happens in one of two ways, set by a mode bit. In automatic mode the level is released as the second acknowledge pulse ends. Otherwise software releases it with an end-of-interrupt command. That command can be non-specific, which frees the highest-priority level in service, or specific, which frees one named level. A small register port writes the mask, the base and the mode, issues those commands, and reads back the pending, in-service and mask registers. The bidirectional data bus is modelled as separate `din`, `dout` and `dout_oe` signals.

Top module: `pic_ctrl`

## Requirements
- R1: A request line sampled high at a clock edge sets its pending (IRR) bit at that edge. The bit stays set until the first acknowledge pulse takes that level. When a clear and a request for the same level come in the same cycle, the clear wins.
- R2: A level whose mask (IMR) bit is 1 never raises `int_req` and is never taken by an acknowledge.
- R3: Among eligible pending levels, the lowest index wins.
- R4: `int_req` is high in any cycle in which at least one pending, unmasked level is eligible. It is driven combinationally from the registered state, so it follows one clock edge after the request is sampled.
- R5: The rising edge of the first acknowledge pulse sets the winner's in-service (ISR) bit and clears its IRR bit at that clock edge. `dout_oe` stays low for the whole first pulse unless a register read is active.
- R6: While the second acknowledge pulse is high, `dout_oe` is 1 and `dout` is `{base[7:3], level[2:0]}`. This takes precedence over any register read.
- R7: When mode bit 0 is 1, the winner's ISR bit clears at the clock edge where the second pulse is seen low. When mode bit 0 is 0, that ISR bit stays set.
- R8: A pending level is eligible only if no ISR bit of equal or higher priority (equal or lower index) is set.
- R9: A write with `reg_sel`=0 is an end-of-interrupt command. If `din[3]`=0, it clears the lowest-index set ISR bit. If `din[3]`=1, it clears ISR bit `din[2:0]`.
- R10: With `rd_en`=1 and no vector being driven, `dout_oe`=1 and `dout` returns the register chosen by `reg_sel`: 0 gives IRR, 1 gives ISR, 2 gives IMR, 3 gives `{base[7:3], 2'b00, mode}`.
- R11: Writes with `wr_en`=1 use `reg_sel` as follows: 1 writes the mode from `din[0]`, 2 writes IMR from `din`, 3 writes the base from `din[7:3]`.
- R12: After a synchronous reset, IRR, ISR, IMR, the base and the mode are all 0, `int_req` is 0, and the acknowledge sequence is idle.
- R13: If no level is eligible at the first acknowledge pulse, no ISR bit changes, the second pulse drives `{base[7:3], 3'b111}`, and the end of the second pulse releases nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 8 | Request lines, index 0 highest priority |
| int_req | output | 1 | Interrupt line to the processor |
| ack | input | 1 | Acknowledge pulses, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read enable |
| reg_sel | input | 2 | Register / command select |
| din | input | 8 | Data bus, inbound half |
| dout | output | 8 | Data bus, outbound half |
| dout_oe | output | 1 | Output enable for `dout` |

## Verification
All state sits in registers that update at a clock edge. `int_req`, `dout` and `dout_oe` are combinational functions of that state and of the `ack`, `rd_en` and `reg_sel` inputs in the current cycle. So a request, a write or an acknowledge edge shows up at the outputs in the cycle after the edge that samples it. The vector and the read data, however, appear in the same cycle the second pulse or the read is presented. The bench drives inputs at the falling edge and compares the outputs 1 ns later against a model that advances only at the rising edge. Each result is therefore checked exactly in the cycle its timing makes it due. Randomly timed acknowledge levels make the pulses vary in width and spacing, and they overlap register writes and reads.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int PIC_LEVELS  = 8;
    localparam int PIC_DATA_W  = 8;
    localparam int PIC_SEL_W   = 2;

    // Register-port select codes
    localparam logic [PIC_SEL_W-1:0] SEL_EOI_IRR  = 2'd0;  // write: EOI command, read: IRR
    localparam logic [PIC_SEL_W-1:0] SEL_MODE_ISR = 2'd1;  // write: mode,        read: ISR
    localparam logic [PIC_SEL_W-1:0] SEL_MASK     = 2'd2;  // write/read: IMR
    localparam logic [PIC_SEL_W-1:0] SEL_BASE_CFG = 2'd3;  // write: base,        read: config

    // Acknowledge handshake phases
    typedef enum logic [1:0] {
        ACK_IDLE   = 2'd0,
        ACK_FIRST  = 2'd1,
        ACK_GAP    = 2'd2,
        ACK_SECOND = 2'd3
    } ack_phase_t;

    // Decoded end-of-interrupt request
    typedef struct packed {
        logic       nonspec;
        logic       spec;
        logic [2:0] level;
    } eoi_cmd_t;

endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] irq,
    input  logic [N-1:0] take,
    output logic [N-1:0] irr
);

    logic [N-1:0] irr_q;

    always_ff @(posedge clk) begin
        if (rst) irr_q <= '0;
        else     irr_q <= (irr_q | irq) & ~take;
    end

    assign irr = irr_q;

    // Pending bits only drop through a take (R1)
    p_irr_sticky_r1: assert property (@(posedge clk) disable iff (rst)
        (take == '0) |=> ((irr_q & $past(irr_q)) == $past(irr_q)));

endmodule

// File: rtl/pic_resolver.sv
module pic_resolver #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  irr,
    input  logic [N-1:0]  imr,
    input  logic [N-1:0]  isr,
    output logic          hit,
    output logic [LW-1:0] level,
    output logic [N-1:0]  grant
);

    logic [N-1:0] live;
    assign live = irr & ~imr;

    always_comb begin
        logic allow;
        allow = 1'b1;
        hit   = 1'b0;
        level = '0;
        for (int i = 0; i < N; i++) begin
            if (isr[i]) allow = 1'b0;
            if (allow && live[i] && !hit) begin
                hit   = 1'b1;
                level = LW'(i);
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_grant
        assign grant[g] = hit && (level == LW'(g));
    end

endmodule

// File: rtl/pic_in_service.sv
module pic_in_service #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  set_vec,
    input  logic          eoi_ns,
    input  logic          eoi_sp,
    input  logic [LW-1:0] eoi_level,
    input  logic          auto_clr,
    input  logic [LW-1:0] auto_level,
    output logic [N-1:0]  isr
);

    logic [N-1:0] isr_q;
    logic [N-1:0] top_bit;
    logic [N-1:0] clr_vec;

    // Highest-priority (lowest index) set bit
    always_comb begin
        logic seen;
        seen    = 1'b0;
        top_bit = '0;
        for (int i = 0; i < N; i++) begin
            if (isr_q[i] && !seen) begin
                top_bit[i] = 1'b1;
                seen       = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_clr
        assign clr_vec[g] = (eoi_ns && top_bit[g])
                          || (eoi_sp && (eoi_level == LW'(g)))
                          || (auto_clr && (auto_level == LW'(g)));
    end

    always_ff @(posedge clk) begin
        if (rst) isr_q <= '0;
        else     isr_q <= (isr_q | set_vec) & ~clr_vec;
    end

    assign isr = isr_q;

    // At most one level enters service per edge (R5)
    p_single_entry_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(isr_q & ~$past(isr_q)) <= 1));

    // Non-specific EOI removes the top bit (R9)
    p_ns_eoi_r9: assert property (@(posedge clk) disable iff (rst)
        (eoi_ns && !eoi_sp && !auto_clr && (set_vec == '0)) |=>
        ($countones(isr_q) == $countones($past(isr_q)) - (($past(isr_q) != '0) ? 1 : 0)));

endmodule

// File: rtl/pic_ack_seq.sv
module pic_ack_seq
    import pic_pkg::*;
#(
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ack,
    input  logic          hit,
    input  logic [LW-1:0] level,
    output logic          take,
    output logic          finish,
    output logic          drive_vec,
    output logic          in_first,
    output logic          spur,
    output logic [LW-1:0] lvl_q
);

    ack_phase_t ph_q, ph_d;
    logic       spur_q;

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            ACK_IDLE:   if (ack)  ph_d = ACK_FIRST;
            ACK_FIRST:  if (!ack) ph_d = ACK_GAP;
            ACK_GAP:    if (ack)  ph_d = ACK_SECOND;
            ACK_SECOND: if (!ack) ph_d = ACK_IDLE;
            default:              ph_d = ACK_IDLE;
        endcase
    end

    assign take      = (ph_q == ACK_IDLE) && ack;
    assign finish    = (ph_q == ACK_SECOND) && !ack;
    assign drive_vec = ack && ((ph_q == ACK_GAP) || (ph_q == ACK_SECOND));
    assign in_first  = (ph_q == ACK_FIRST);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= ACK_IDLE;
            lvl_q  <= '0;
            spur_q <= 1'b0;
        end else begin
            ph_q <= ph_d;
            if (take) begin
                lvl_q  <= hit ? level : '1;
                spur_q <= !hit;
            end
        end
    end

    assign spur = spur_q;

    // Phase can only advance one step per edge (R6)
    p_phase_step_r6: assert property (@(posedge clk) disable iff (rst)
        (ph_q == ACK_GAP) |=> ((ph_q == ACK_GAP) || (ph_q == ACK_SECOND)));

    // A spurious take always carries the all-ones level (R13)
    p_spur_level_r13: assert property (@(posedge clk) disable iff (rst)
        (take && !hit) |=> (spur_q && (lvl_q == '1)));

endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
#(
    parameter int N  = PIC_LEVELS,
    parameter int DW = PIC_DATA_W,
    parameter int SW = PIC_SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  irq,
    output logic          int_req,
    input  logic          ack,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [SW-1:0] reg_sel,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_oe
);

    localparam int LW = $clog2(N);
    localparam int BW = DW - LW;

    logic [N-1:0]  imr_q;
    logic [BW-1:0] base_q;
    logic          aeoi_q;

    logic [N-1:0]  irr, isr, grant;
    logic          hit;
    logic [LW-1:0] level;
    logic          take, finish, drive_vec, in_first, spur;
    logic [LW-1:0] lvl_q;
    logic [N-1:0]  take_vec;
    eoi_cmd_t      eoi;

    // ---------------- register port writes ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            imr_q  <= '0;
            base_q <= '0;
            aeoi_q <= 1'b0;
        end else if (wr_en) begin
            unique case (reg_sel)
                SEL_MODE_ISR: aeoi_q <= din[0];
                SEL_MASK:     imr_q  <= din[N-1:0];
                SEL_BASE_CFG: base_q <= din[DW-1:LW];
                default:      ;
            endcase
        end
    end

    always_comb begin
        eoi.nonspec = wr_en && (reg_sel == SEL_EOI_IRR) && !din[LW];
        eoi.spec    = wr_en && (reg_sel == SEL_EOI_IRR) &&  din[LW];
        eoi.level   = din[LW-1:0];
    end

    assign take_vec = (take && hit) ? grant : '0;

    // ---------------- datapath ----------------
    pic_req_latch #(.N(N)) u_irr (
        .clk  (clk),
        .rst  (rst),
        .irq  (irq),
        .take (take_vec),
        .irr  (irr)
    );

    pic_resolver #(.N(N), .LW(LW)) u_pri (
        .irr   (irr),
        .imr   (imr_q),
        .isr   (isr),
        .hit   (hit),
        .level (level),
        .grant (grant)
    );

    pic_ack_seq #(.LW(LW)) u_ack (
        .clk       (clk),
        .rst       (rst),
        .ack       (ack),
        .hit       (hit),
        .level     (level),
        .take      (take),
        .finish    (finish),
        .drive_vec (drive_vec),
        .in_first  (in_first),
        .spur      (spur),
        .lvl_q     (lvl_q)
    );

    pic_in_service #(.N(N), .LW(LW)) u_isr (
        .clk        (clk),
        .rst        (rst),
        .set_vec    (take_vec),
        .eoi_ns     (eoi.nonspec),
        .eoi_sp     (eoi.spec),
        .eoi_level  (eoi.level),
        .auto_clr   (finish && aeoi_q && !spur),
        .auto_level (lvl_q),
        .isr        (isr)
    );

    // ---------------- outputs ----------------
    assign int_req = hit;
    assign dout_oe = drive_vec || rd_en;

    always_comb begin
        if (drive_vec) begin
            dout = {base_q, lvl_q};
        end else if (rd_en) begin
            unique case (reg_sel)
                SEL_EOI_IRR:  dout = DW'(irr);
                SEL_MODE_ISR: dout = DW'(isr);
                SEL_MASK:     dout = DW'(imr_q);
                default:      dout = {base_q, {(LW-1){1'b0}}, aeoi_q};
            endcase
        end else begin
            dout = '0;
        end
    end

    // ---------------- assertions ----------------
    p_grant_unmasked_r2: assert property (@(posedge clk) disable iff (rst)
        ((grant & imr_q) == '0));

    p_grant_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    p_first_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (in_first && !rd_en) |-> !dout_oe);

    p_take_moves_r5: assert property (@(posedge clk) disable iff (rst)
        (take && hit && !wr_en) |=> (isr[$past(level)] && !irr[$past(level)]));

    p_aeoi_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (finish && aeoi_q && !spur) |=> !isr[$past(lvl_q)]);

    p_blocked_r8: assert property (@(posedge clk) disable iff (rst)
        (hit && isr[0]) |-> 1'b0);

endmodule

// File: tb/sim_pic_ctrl.sv
`timescale 1ns/1ps
module sim_pic_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] irq;
    logic       int_req;
    logic       ack;
    logic       wr_en;
    logic       rd_en;
    logic [1:0] reg_sel;
    logic [7:0] din;
    logic [7:0] dout;
    logic       dout_oe;

    always #2 clk = ~clk;   // 250 MHz

    pic_ctrl u0 (
        .clk(clk), .rst(rst), .irq(irq), .int_req(int_req), .ack(ack),
        .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel), .din(din),
        .dout(dout), .dout_oe(dout_oe)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference model state
    logic [7:0] m_irr, m_isr, m_imr, m_base;
    logic       m_aeoi, m_spur;
    int         m_ph;
    logic [2:0] m_lvl;

    function automatic int pick(input logic [7:0] pend, mask, insvc);
        for (int i = 0; i < 8; i++) begin
            if (insvc[i]) return -1;
            if (pend[i] && !mask[i]) return i;
        end
        return -1;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_irr = 0; m_isr = 0; m_imr = 0; m_base = 0;
        m_aeoi = 0; m_spur = 0; m_ph = 0; m_lvl = 0;
    endtask

    task automatic model_edge();
        int         w;
        logic [7:0] irr_n, isr_set, isr_clr;
        w       = pick(m_irr, m_imr, m_isr);
        irr_n   = m_irr | irq;
        isr_set = 0;
        isr_clr = 0;
        case (m_ph)
            0: if (ack) begin
                   m_ph = 1;
                   if (w >= 0) begin
                       irr_n[w] = 1'b0; isr_set[w] = 1'b1;
                       m_lvl = 3'(w); m_spur = 0;
                   end else begin
                       m_lvl = 3'd7; m_spur = 1;
                   end
               end
            1: if (!ack) m_ph = 2;
            2: if (ack) m_ph = 3;
            default: if (!ack) begin
                   m_ph = 0;
                   if (m_aeoi && !m_spur) isr_clr[m_lvl] = 1'b1;
               end
        endcase
        if (wr_en) begin
            case (reg_sel)
                2'd0: begin
                    if (din[3]) isr_clr[din[2:0]] = 1'b1;
                    else begin
                        for (int i = 0; i < 8; i++)
                            if (m_isr[i]) begin isr_clr[i] = 1'b1; break; end
                    end
                end
                2'd1: m_aeoi = din[0];
                2'd2: m_imr  = din;
                default: m_base = {din[7:3], 3'b000};
            endcase
        end
        m_irr = irr_n;
        m_isr = (m_isr | isr_set) & ~isr_clr;
    endtask

    task automatic check_outputs();
        logic exp_vec, exp_oe;
        exp_vec = ack && (m_ph == 2 || m_ph == 3);
        exp_oe  = exp_vec || rd_en;
        chk("R4 R2 R8 int_req", {7'd0, int_req}, {7'd0, pick(m_irr, m_imr, m_isr) >= 0});
        chk(m_ph == 1 ? "R5 dout_oe" : "R6 R10 dout_oe", {7'd0, dout_oe}, {7'd0, exp_oe});
        if (exp_vec)
            chk(m_spur ? "R13 vector" : "R6 R3 vector", dout, {m_base[7:3], m_lvl});
        else if (rd_en) begin
            case (reg_sel)
                2'd0:    chk("R10 R1 irr read", dout, m_irr);
                2'd1:    chk("R10 R7 R9 isr read", dout, m_isr);
                2'd2:    chk("R10 R11 imr read", dout, m_imr);
                default: chk("R10 R11 cfg read", dout, {m_base[7:3], 2'b00, m_aeoi});
            endcase
        end
    endtask

    // Called just after a falling edge
    task automatic step(input logic [7:0] i_irq, input logic i_ack, input logic i_wr,
                        input logic i_rd, input logic [1:0] i_sel, input logic [7:0] i_din);
        irq = i_irq; ack = i_ack; wr_en = i_wr; rd_en = i_rd; reg_sel = i_sel; din = i_din;
        #1;
        check_outputs();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic ack_pair();
        step(0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1; irq = 0; ack = 0; wr_en = 0; rd_en = 0; reg_sel = 0; din = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R12: reset state at the ports
        for (int s = 0; s < 4; s++) begin
            reg_sel = 2'(s); rd_en = 1; #1;
            chk("R12 reset read", dout, 8'h00);
            chk("R12 reset int", {7'd0, int_req}, 8'h00);
            @(negedge clk);
        end
        rd_en = 0;

        // Directed: base 0x40, levels 5 and 2 together, fixed priority
        step(0, 0, 1, 0, 2'd3, 8'h47);
        step(8'h24, 0, 0, 0, 0, 0);
        ack_pair();                            // takes level 2 (R3 R5 R6)
        step(0, 0, 0, 1, 2'd1, 0);             // ISR = 0x04 (R5)
        chk("R8 lower level blocked", {7'd0, int_req}, 8'h00);
        step(0, 0, 1, 0, 2'd0, 8'h00);         // non-specific EOI (R9)
        chk("R9 level 5 eligible again", {7'd0, int_req}, 8'h01);
        ack_pair();                            // takes level 5
        step(0, 0, 1, 0, 2'd0, 8'h0D);         // specific EOI level 5 (R9)
        step(0, 0, 0, 1, 2'd1, 0);
        // R13: no eligible level
        ack_pair();
        // R7: automatic mode
        step(0, 0, 1, 0, 2'd1, 8'h01);
        step(8'h80, 0, 0, 0, 0, 0);
        ack_pair();
        step(0, 0, 0, 1, 2'd1, 0);
        // R2: masked level ignored
        step(0, 0, 1, 0, 2'd2, 8'h08);
        step(8'h08, 0, 0, 1, 2'd0, 0);
        chk("R2 masked no int", {7'd0, int_req}, 8'h00);
        ack_pair();
        step(0, 0, 1, 0, 2'd2, 8'h00);

        // Constrained random mix
        begin
            logic a_lvl;
            a_lvl = 0;
            for (int n = 0; n < 8000; n++) begin
                logic [7:0] r_irq, r_din;
                logic       r_wr, r_rd;
                logic [1:0] r_sel;
                if ($urandom % 4 == 0) a_lvl = ~a_lvl;
                r_irq = ($urandom % 5 == 0) ? (8'h01 << ($urandom % 8)) : 8'h00;
                r_wr  = ($urandom % 10 == 0);
                r_rd  = ($urandom % 4 == 0);
                r_sel = 2'($urandom % 4);
                r_din = 8'($urandom);
                if (r_wr && r_sel == 2'd2) r_din = r_din & 8'($urandom) & 8'($urandom);
                step(r_irq, a_lvl, r_wr, r_rd, r_sel, r_din);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule